// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Threshold Registers

This block sits beside a FIFO's storage and produces its two early-warning flags. It holds two offsets: `n`, the distance from empty at which the almost-empty flag asserts, and `m`, the distance from full at which the almost-full flag asserts. The FIFO core gives the block its fill level twice, once as seen in the write-clock domain and once as seen in the read-clock domain. The block compares each fill level against the matching offset and drives two active-low, registered flags.

The level of the load-select pin while master reset is held does two things. It picks the default offsets, and it picks the only method by which the offsets may be changed afterwards. With the pin low, both offsets start at 127 and may be rewritten over the parallel input bus. With the pin high, both start at 1023 and may be rewritten only one bit at a time through a serial input. In either method the offsets are read back over the parallel output bus. A parallel access goes to the almost-empty offset first and to the almost-full offset next, and keeps alternating. Reads and writes keep separate alternation state.

Top module: `almostFlagOffsets`

## Requirements
- R1: With `ldN` low while `mrst` is high, both offsets become 127 and the block enters parallel-load mode.
- R2: With `ldN` high while `mrst` is high, both offsets become 1023 and the block enters serial-load mode.
- R3: In serial mode, each rising `wrClk` edge with `ldN` and `senN` both low stores `serIn` into the next bit of the offset chain. The chain is the almost-empty offset bits 0 to W-1, then the almost-full offset bits 0 to W-1. After 2·W bits it wraps to bit 0 of the almost-empty offset. No bit is stored while `ldN` is high.
- R4: While `senN` is high, no serial bit is stored and both offsets keep their values.
- R5: In parallel mode, each `wrClk` edge with `ldN` and `wenN` both low writes `dataIn` to one offset. The first write after reset goes to the almost-empty offset, the next to the almost-full offset, and so on alternately. Parallel writes are ignored in serial mode, and serial bits are ignored in parallel mode.
- R6: In either mode, each `rdClk` edge with `ldN` and `renN` both low loads one offset onto `dataOut`, almost-empty first and then alternating. The read alternation is independent of the write alternation. `dataOut` holds its value on all other edges.
- R7: `paeN` is registered on `rdClk` and is low in the cycle after an edge at which `rdFill` ≤ n, high otherwise.
- R8: `pafN` is registered on `wrClk` and is low in the cycle after an edge at which `wrFill` ≥ D − m, high otherwise.
- R9: While `mrst` is high, `paeN` is low, `pafN` is high, `dataOut` is zero, and both alternations point to the almost-empty offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-domain clock |
| rdClk | input | 1 | Read-domain clock |
| mrst | input | 1 | Master reset, active high, synchronous to each clock |
| ldN | input | 1 | Load select; mode choice during reset, offset access after |
| senN | input | 1 | Serial bit enable, active low |
| serIn | input | 1 | Serial offset bit |
| wenN | input | 1 | Write enable, active low |
| renN | input | 1 | Read enable, active low |
| dataIn | input | W | Parallel offset write data |
| wrFill | input | CW | Fill level in write domain (CW = clog2(D)+1) |
| rdFill | input | CW | Fill level in read domain |
| dataOut | output | W | Offset readback data |
| paeN | output | 1 | Almost-empty flag, active low |
| pafN | output | 1 | Almost-full flag, active low |

## Verification
On every cycle, the embedded assertions check these properties. Each flag follows its threshold comparison one edge later. The offsets change only on a serial or parallel write strobe. The serial bit pointer stays inside the 2·W chain. `dataOut` is stable when no read is strobed. The serial and parallel write strobes are never active together. Only the bench scenarios can show that the reset-time pin level picks the right defaults, and that the serial bit order and wrap land bits in the expected positions. The same holds for the separate alternation of parallel reads and writes, and for full threshold sweeps of the fill level from empty to full.

// File: rtl/almostOffPkg.sv
package almostOffPkg;

  // write-domain strobes from control to datapath
  typedef struct packed {
    logic serLoad;    // store one serial bit
    logic serToPaf;   // serial bit belongs to the almost-full offset
    logic parWrite;   // parallel write of dataIn
    logic parToPaf;   // parallel write targets the almost-full offset
  } wrStrobes_t;

  // read-domain strobes from control to datapath
  typedef struct packed {
    logic rdAccess;   // load an offset onto dataOut
    logic rdFromPaf;  // readback selects the almost-full offset
  } rdStrobes_t;

endpackage

// File: rtl/almostOffCtrl.sv
module almostOffCtrl
  import almostOffPkg::*;
#(
  parameter int W = 12
) (
  input  logic                        wrClk,
  input  logic                        rdClk,
  input  logic                        mrst,
  input  logic                        ldN,
  input  logic                        senN,
  input  logic                        wenN,
  input  logic                        renN,
  output wrStrobes_t                  wrStb,
  output rdStrobes_t                  rdStb,
  output logic [$clog2(2*W)-1:0]      bitIdx
);
  localparam int IW = $clog2(2 * W);
  localparam logic [IW-1:0] LAST_BIT = IW'(2 * W - 1);
  localparam logic [IW-1:0] HALF = IW'(W);

  logic serialMode;
  logic wrToggle;
  logic rdToggle;

  always_ff @(posedge wrClk) begin
    if (mrst) begin
      serialMode <= ldN;
      wrToggle   <= 1'b0;
      bitIdx     <= '0;
    end else begin
      if (wrStb.parWrite) wrToggle <= ~wrToggle;
      if (wrStb.serLoad) bitIdx <= (bitIdx == LAST_BIT) ? '0 : bitIdx + 1'b1;
    end
  end

  always_ff @(posedge rdClk) begin
    if (mrst) rdToggle <= 1'b0;
    else if (rdStb.rdAccess) rdToggle <= ~rdToggle;
  end

  always_comb begin
    wrStb.serLoad  = !mrst && serialMode && !ldN && !senN;
    wrStb.serToPaf = (bitIdx >= HALF);
    wrStb.parWrite = !mrst && !serialMode && !ldN && !wenN;
    wrStb.parToPaf = wrToggle;
    rdStb.rdAccess = !mrst && !ldN && !renN;
    rdStb.rdFromPaf = rdToggle;
  end

  // R3
  bit_idx_range_chk: assert property (@(posedge wrClk) disable iff (mrst)
    bitIdx <= LAST_BIT);

  // R5
  one_write_method_chk: assert property (@(posedge wrClk) disable iff (mrst)
    !(wrStb.serLoad && wrStb.parWrite));

  // R3
  ser_advance_chk: assert property (@(posedge wrClk) disable iff (mrst)
    (wrStb.serLoad && bitIdx != LAST_BIT) |=> (bitIdx == $past(bitIdx) + 1'b1));

endmodule

// File: rtl/almostOffDatapath.sv
module almostOffDatapath
  import almostOffPkg::*;
#(
  parameter int W      = 12,
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023
) (
  input  logic                        wrClk,
  input  logic                        rdClk,
  input  logic                        mrst,
  input  logic                        ldN,
  input  logic                        serIn,
  input  logic [W-1:0]                dataIn,
  input  wrStrobes_t                  wrStb,
  input  rdStrobes_t                  rdStb,
  input  logic [$clog2(2*W)-1:0]      bitIdx,
  output logic [W-1:0]                paeOff,
  output logic [W-1:0]                pafOff,
  output logic [W-1:0]                dataOut
);
  localparam int IW = $clog2(2 * W);
  localparam logic [W-1:0] LO_VAL = W'(DEF_LO);
  localparam logic [W-1:0] HI_VAL = W'(DEF_HI);

  logic [IW-1:0] localBit;

  always_comb begin
    localBit = wrStb.serToPaf ? (bitIdx - IW'(W)) : bitIdx;
  end

  always_ff @(posedge wrClk) begin
    if (mrst) begin
      paeOff <= ldN ? HI_VAL : LO_VAL;
      pafOff <= ldN ? HI_VAL : LO_VAL;
    end else if (wrStb.parWrite) begin
      if (wrStb.parToPaf) pafOff <= dataIn;
      else                paeOff <= dataIn;
    end else if (wrStb.serLoad) begin
      for (int i = 0; i < W; i++) begin
        if (localBit == IW'(i)) begin
          if (wrStb.serToPaf) pafOff[i] <= serIn;
          else                paeOff[i] <= serIn;
        end
      end
    end
  end

  always_ff @(posedge rdClk) begin
    if (mrst) dataOut <= '0;
    else if (rdStb.rdAccess) dataOut <= rdStb.rdFromPaf ? pafOff : paeOff;
  end

  // R4
  offsets_hold_chk: assert property (@(posedge wrClk) disable iff (mrst)
    (!wrStb.serLoad && !wrStb.parWrite) |=> ($stable(paeOff) && $stable(pafOff)));

  // R6
  readback_hold_chk: assert property (@(posedge rdClk) disable iff (mrst)
    !rdStb.rdAccess |=> $stable(dataOut));

endmodule

// File: rtl/almostFlagCmp.sv
module almostFlagCmp #(
  parameter int W = 12,
  parameter int D = 4096
) (
  input  logic                        wrClk,
  input  logic                        rdClk,
  input  logic                        mrst,
  input  logic [$clog2(D):0]          wrFill,
  input  logic [$clog2(D):0]          rdFill,
  input  logic [W-1:0]                paeOff,
  input  logic [W-1:0]                pafOff,
  output logic                        paeN,
  output logic                        pafN
);
  localparam int CW = $clog2(D) + 1;

  logic [CW-1:0] nExt;
  logic [CW-1:0] fullThr;

  always_comb begin
    nExt    = CW'(paeOff);
    fullThr = CW'(D) - CW'(pafOff);
  end

  always_ff @(posedge rdClk) begin
    if (mrst) paeN <= 1'b0;
    else      paeN <= !(rdFill <= nExt);
  end

  always_ff @(posedge wrClk) begin
    if (mrst) pafN <= 1'b1;
    else      pafN <= !(wrFill >= fullThr);
  end

  // R7
  pae_low_chk: assert property (@(posedge rdClk) disable iff (mrst)
    (rdFill <= CW'(paeOff)) |=> !paeN);

  // R7
  pae_high_chk: assert property (@(posedge rdClk) disable iff (mrst)
    (rdFill > CW'(paeOff)) |=> paeN);

  // R8
  paf_low_chk: assert property (@(posedge wrClk) disable iff (mrst)
    (CW'(wrFill) + CW'(pafOff) >= CW'(D)) |=> !pafN);

endmodule

// File: rtl/almostFlagOffsets.sv
module almostFlagOffsets
  import almostOffPkg::*;
#(
  parameter int W      = 12,
  parameter int D      = 4096,
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023
) (
  input  logic                  wrClk,
  input  logic                  rdClk,
  input  logic                  mrst,
  input  logic                  ldN,
  input  logic                  senN,
  input  logic                  serIn,
  input  logic                  wenN,
  input  logic                  renN,
  input  logic [W-1:0]          dataIn,
  input  logic [$clog2(D):0]    wrFill,
  input  logic [$clog2(D):0]    rdFill,
  output logic [W-1:0]          dataOut,
  output logic                  paeN,
  output logic                  pafN
);
  localparam int IW = $clog2(2 * W);

  wrStrobes_t    wrStb;
  rdStrobes_t    rdStb;
  logic [IW-1:0] bitIdx;
  logic [W-1:0]  paeOff;
  logic [W-1:0]  pafOff;

  almostOffCtrl #(.W(W)) ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .mrst(mrst),
    .ldN(ldN), .senN(senN), .wenN(wenN), .renN(renN),
    .wrStb(wrStb), .rdStb(rdStb), .bitIdx(bitIdx)
  );

  almostOffDatapath #(.W(W), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) dpath (
    .wrClk(wrClk), .rdClk(rdClk), .mrst(mrst), .ldN(ldN),
    .serIn(serIn), .dataIn(dataIn), .wrStb(wrStb), .rdStb(rdStb),
    .bitIdx(bitIdx), .paeOff(paeOff), .pafOff(pafOff), .dataOut(dataOut)
  );

  almostFlagCmp #(.W(W), .D(D)) flags (
    .wrClk(wrClk), .rdClk(rdClk), .mrst(mrst),
    .wrFill(wrFill), .rdFill(rdFill),
    .paeOff(paeOff), .pafOff(pafOff),
    .paeN(paeN), .pafN(pafN)
  );

endmodule

// File: tb/almostFlagOffsets_test.sv
`timescale 1ns/1ps
module almostFlagOffsets_test;
  localparam int W  = 12;
  localparam int D  = 4096;
  localparam int CW = $clog2(D) + 1;

  logic clk = 1'b0;
  logic mrst = 1'b1, ldN = 1'b1, senN = 1'b1, serIn = 1'b0, wenN = 1'b1, renN = 1'b1;
  logic [W-1:0]  dataIn = '0;
  logic [CW-1:0] wrFill = '0, rdFill = '0;
  logic [W-1:0]  dataOut;
  logic paeN, pafN;

  int total = 0;
  int bad = 0;
  int rdSel = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  almostFlagOffsets #(.W(W), .D(D)) uut (
    .wrClk(clk), .rdClk(clk), .mrst(mrst), .ldN(ldN), .senN(senN),
    .serIn(serIn), .wenN(wenN), .renN(renN), .dataIn(dataIn),
    .wrFill(wrFill), .rdFill(rdFill), .dataOut(dataOut),
    .paeN(paeN), .pafN(pafN)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic level);
    mrst = 1'b1; ldN = level; wrFill = '0; rdFill = '0;
    tick(); tick();
    check("R9 paeN in reset", int'(paeN), 0);
    check("R9 pafN in reset", int'(pafN), 1);
    check("R9 dataOut in reset", int'(dataOut), 0);
    mrst = 1'b0; ldN = 1'b1;
    rdSel = 0;
    tick();
  endtask

  task automatic readBack(input string req, input int expPae, input int expPaf);
    ldN = 1'b0; renN = 1'b0;
    tick();
    check(req, int'(dataOut), (rdSel == 0) ? expPae : expPaf);
    rdSel = 1 - rdSel;
    ldN = 1'b1; renN = 1'b1;
  endtask

  task automatic readBoth(input string req, input int expPae, input int expPaf);
    readBack(req, expPae, expPaf);
    readBack(req, expPae, expPaf);
  endtask

  task automatic parWrite(input int v);
    ldN = 1'b0; wenN = 1'b0; dataIn = W'(v);
    tick();
    ldN = 1'b1; wenN = 1'b1;
  endtask

  task automatic serBit(input logic b);
    ldN = 1'b0; senN = 1'b0; serIn = b;
    tick();
    ldN = 1'b1; senN = 1'b1;
  endtask

  task automatic sweep(input int n, input int m);
    for (int f = 0; f <= D; f++) begin
      wrFill = CW'(f); rdFill = CW'(f);
      tick();
      check("R7 paeN sweep", int'(paeN), (f <= n) ? 0 : 1);
      check("R8 pafN sweep", int'(pafN), (f >= D - m) ? 0 : 1);
    end
    wrFill = '0; rdFill = '0;
    tick();
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int pv, fv;
    // ---- parallel mode ----
    doReset(1'b0);
    readBoth("R1 default 127", 127, 127);
    sweep(127, 127);
    // R5 alternation, R6 independent read toggle
    parWrite(5);
    readBack("R5 first write to pae", 5, 127);
    parWrite(300);
    readBack("R6 second read from paf", 5, 300);
    // R3/R5 serial bits ignored in parallel mode
    for (int i = 0; i < 5; i++) serBit(1'b1);
    readBoth("R5 serial ignored in parallel mode", 5, 300);
    // R6 no read when ldN high
    ldN = 1'b1; renN = 1'b0;
    tick(); tick();
    check("R6 dataOut holds with ldN high", int'(dataOut), 300);
    renN = 1'b1;
    // R5 wenN with ldN high is not an offset write
    ldN = 1'b1; wenN = 1'b0; dataIn = 12'd77;
    tick();
    wenN = 1'b1;
    readBoth("R5 write ignored with ldN high", 5, 300);
    sweep(5, 300);

    // ---- serial mode ----
    doReset(1'b1);
    readBoth("R2 default 1023", 1023, 1023);
    sweep(1023, 1023);
    pv = 12'h0A5; fv = 12'h123;
    for (int i = 0; i < W; i++) serBit(pv[i]);
    for (int i = 0; i < W; i++) serBit(fv[i]);
    readBoth("R3 serial load order", 12'h0A5, 12'h123);
    for (int i = 0; i < 3; i++) serBit(1'b1);
    readBoth("R3 serial wrap to pae", 12'h0A7, 12'h123);
    // R4 senN high with ldN low
    ldN = 1'b0; senN = 1'b1; serIn = 1'b0;
    for (int i = 0; i < 6; i++) tick();
    ldN = 1'b1;
    readBoth("R4 senN high holds", 12'h0A7, 12'h123);
    // R3 senN low with ldN high stores nothing
    ldN = 1'b1; senN = 1'b0; serIn = 1'b0;
    for (int i = 0; i < 6; i++) tick();
    senN = 1'b1;
    readBoth("R3 ldN high no shift", 12'h0A7, 12'h123);
    // R5 parallel write ignored in serial mode
    parWrite(9); parWrite(10);
    readBoth("R5 parallel ignored in serial mode", 12'h0A7, 12'h123);
    sweep(12'h0A7, 12'h123);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule